// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Sequencer

This block raises a base X to an exponent E modulo an odd modulus M. It scans the exponent from its least significant bit upward. The block keeps a running power Z, which is squared for each exponent bit, and an accumulator P, which takes a product with Z whenever the current bit is set. Every product is a Montgomery product. A single bit-serial multiplier computes it over W+2 iterations, and that multiplier uses a five-input carry-save compressor. No carry chain is ever rippled inside the loop.

Both P and Z remain as pairs of words whose sum is the value they stand for. The caller supplies the domain-entry constant K = 2^(2(W+2)) mod M. One product with K brings the base into the Montgomery domain. A last product with the constant 1 brings the result back out. Only after that last product is the pair added into one binary word. A conditional subtraction of M then lands the result in the range 0 to M-1.

The interface is a pulse-driven handshake. The caller raises start for one cycle while the block is idle. It then waits for the single-cycle done pulse and reads the result. The result stays valid until the next accepted start.

Top module: `mexp_core`

## Requirements
- R1: A start pulse while busy is low captures base, exponent, modulus and K, and busy is high from the next cycle on.
- R2: For odd M with 3 <= M < 2^W, X < M, K = 2^(2(W+2)) mod M and any EW-bit E, the result equals X^E mod M.
- R3: An exponent of zero yields 1, also when the base is zero.
- R4: A zero base with a nonzero exponent yields 0.
- R5: The result always lies in 0..M-1. For example, 0^5 mod 9 returns 0 and never 9. Every internal Montgomery product sums to less than 2M.
- R6: Done is high for exactly one cycle, in the same cycle that busy falls. The result does not change from then until the next accepted start.
- R7: A start pulse while busy is high is ignored, and the running operation completes with its original operands.
- R8: During and right after reset, busy and done are low and the result is zero.
- R9: An exponent of one returns the base unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin an exponentiation |
| base_i | input | W | Base X, must be below the modulus |
| exp_i | input | EW | Exponent E |
| mod_i | input | W | Odd modulus M |
| rsq_i | input | W | Domain constant K = 2^(2(W+2)) mod M |
| busy_o | output | 1 | High while an operation runs |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | W | X^E mod M, held until the next start |

## Verification
There are two main fault types. A wrong quotient bit or a lost carry in the compressor corrupts the product in which it happens. A wrong step in the sequencer, such as squaring before multiplying, skipping a bit, or using a stale pair, also corrupts the result. Both show up only at the single done pulse, as a wrong result value, several hundred cycles after start. For that reason the vectors are chosen so that each exponent pattern gives a different answer: all-ones and all-zeros exponents, Fermat exponents, moduli with the top bit set, and a zero base. A handshake fault shows up within one cycle as a missing busy, a done that lasts two cycles, or a result that moves while idle.

// File: rtl/mexp_pkg.sv
`timescale 1ns/1ps
package mexp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_INIT_P = 3'd1,
    ST_INIT_Z = 3'd2,
    ST_MUL    = 3'd3,
    ST_SQR    = 3'd4,
    ST_FINAL  = 3'd5
  } mexp_state_e;
endpackage

// File: rtl/mexp_mont_mul.sv
`timescale 1ns/1ps
module mexp_mont_mul #(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [W+2:0]      a1_i,
  input  logic [W+2:0]      a2_i,
  input  logic [W+2:0]      b1_i,
  input  logic [W+2:0]      b2_i,
  input  logic [W-1:0]      mod_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [W+2:0]      s1_o,
  output logic [W+2:0]      s2_o
);
  localparam int DW  = W + 3;
  localparam int NIT = W + 2;
  localparam int CW  = $clog2(NIT + 1);

  typedef struct packed {
    logic [DW-1:0] s;
    logic [DW-1:0] c;
  } csv_t;

  // three-to-two compression, carry vector already weighted by two
  function automatic csv_t csa3(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                input logic [DW-1:0] z);
    csv_t r;
    r.s = x ^ y ^ z;
    r.c = ((x & y) | (x & z) | (y & z)) << 1;
    return r;
  endfunction

  // parity of the partial sum decides whether M is added
  function automatic logic quot_bit(input logic s1b, input logic s2b, input logic b1b,
                                    input logic b2b, input logic abit);
    return s1b ^ s2b ^ (abit & (b1b ^ b2b));
  endfunction

  // five operands folded into a pair whose sum is even
  function automatic csv_t fold5(input logic [DW-1:0] s1, input logic [DW-1:0] s2,
                                 input logic [DW-1:0] b1, input logic [DW-1:0] b2,
                                 input logic [DW-1:0] m, input logic abit, input logic q);
    csv_t r1, r2, r3;
    r1 = csa3(s1, s2, abit ? b1 : '0);
    r2 = csa3(r1.s, r1.c, abit ? b2 : '0);
    r3 = csa3(r2.s, r2.c, q ? m : '0);
    return r3;
  endfunction

  logic [DW-1:0] s1_q, s2_q, ash1_q, ash2_q, b1_q, b2_q, m_q;
  logic          acy_q, busy_q, done_q;
  logic [CW-1:0] cnt_q;

  logic abit_w, acy_nxt_w, q_w, last_w;
  csv_t fold_w;

  assign abit_w    = ash1_q[0] ^ ash2_q[0] ^ acy_q;
  assign acy_nxt_w = (ash1_q[0] & ash2_q[0]) | (ash1_q[0] & acy_q) | (ash2_q[0] & acy_q);
  assign q_w       = quot_bit(s1_q[0], s2_q[0], b1_q[0], b2_q[0], abit_w);
  assign fold_w    = fold5(s1_q, s2_q, b1_q, b2_q, m_q, abit_w, q_w);
  assign last_w    = (cnt_q == CW'(NIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0; ash1_q <= '0; ash2_q <= '0;
      b1_q <= '0; b2_q <= '0; m_q <= '0;
      acy_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0; cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        ash1_q <= a1_i;  ash2_q <= a2_i;
        b1_q   <= b1_i;  b2_q   <= b2_i;
        m_q    <= DW'(mod_i);
        s1_q   <= '0;    s2_q   <= '0;
        acy_q  <= 1'b0;  cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        s1_q   <= fold_w.s >> 1;
        s2_q   <= fold_w.c >> 1;
        ash1_q <= ash1_q >> 1;
        ash2_q <= ash2_q >> 1;
        acy_q  <= acy_nxt_w;
        cnt_q  <= cnt_q + 1'b1;
        if (last_w) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign s1_o   = s1_q;
  assign s2_o   = s2_q;

  AST_MM_EVEN:  assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !fold_w.s[0]);  // R2
  AST_MM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (({1'b0, s1_q} + {1'b0, s2_q}) < {m_q, 1'b0}));  // R5
  AST_MM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);  // R6
endmodule

// File: rtl/mexp_finalize.sv
`timescale 1ns/1ps
module mexp_finalize #(
  parameter int W = 16
) (
  input  logic [W+2:0] s1_i,
  input  logic [W+2:0] s2_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] res_o
);
  localparam int DW = W + 3;

  // the one carry-propagate add, then a single conditional subtract
  function automatic logic [W-1:0] resolve(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                           input logic [W-1:0] m);
    logic [DW:0] sum, mx;
    sum = {1'b0, a} + {1'b0, b};
    mx  = (DW+1)'(m);
    return W'((sum >= mx) ? (sum - mx) : sum);
  endfunction

  assign res_o = resolve(s1_i, s2_i, mod_i);
endmodule

// File: rtl/mexp_seq.sv
`timescale 1ns/1ps
module mexp_seq
  import mexp_pkg::*;
#(
  parameter int W  = 16,
  parameter int EW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [W-1:0]  base_i,
  input  logic [EW-1:0] exp_i,
  input  logic [W-1:0]  mod_i,
  input  logic [W-1:0]  rsq_i,
  input  logic          mm_busy_i,
  input  logic          mm_done_i,
  input  logic [W+2:0]  mm_s1_i,
  input  logic [W+2:0]  mm_s2_i,
  input  logic [W-1:0]  fin_i,
  output logic          mm_start_o,
  output logic [W+2:0]  mm_a1_o,
  output logic [W+2:0]  mm_a2_o,
  output logic [W+2:0]  mm_b1_o,
  output logic [W+2:0]  mm_b2_o,
  output logic [W-1:0]  mm_mod_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  result_o
);
  localparam int DW = W + 3;
  localparam int IW = (EW > 1) ? $clog2(EW) : 1;
  localparam logic [DW-1:0] ONE = DW'(1);

  mexp_state_e   state_q;
  logic          issued_q, done_q;
  logic [IW-1:0] idx_q;
  logic [W-1:0]  x_q, m_q, k_q, res_q;
  logic [EW-1:0] e_q;
  logic [DW-1:0] p1_q, p2_q, z1_q, z2_q;

  logic          op_done_w, last_bit_w, next_last_w, next_bit_w;
  logic [IW-1:0] nidx_w;

  function automatic mexp_state_e route(input logic bit_set, input logic is_last);
    if (bit_set) return ST_MUL;
    if (is_last) return ST_FINAL;
    return ST_SQR;
  endfunction

  assign op_done_w   = issued_q && mm_done_i;
  assign nidx_w      = idx_q + 1'b1;
  assign last_bit_w  = (idx_q == IW'(EW - 1));
  assign next_last_w = (nidx_w == IW'(EW - 1));
  assign next_bit_w  = e_q[nidx_w];

  always_comb begin
    mm_a1_o = p1_q; mm_a2_o = p2_q; mm_b1_o = ONE; mm_b2_o = '0;
    case (state_q)
      ST_INIT_P: begin mm_a1_o = DW'(k_q); mm_a2_o = '0; mm_b1_o = ONE;      mm_b2_o = '0;   end
      ST_INIT_Z: begin mm_a1_o = DW'(k_q); mm_a2_o = '0; mm_b1_o = DW'(x_q); mm_b2_o = '0;   end
      ST_MUL:    begin mm_a1_o = p1_q;     mm_a2_o = p2_q; mm_b1_o = z1_q;   mm_b2_o = z2_q; end
      ST_SQR:    begin mm_a1_o = z1_q;     mm_a2_o = z2_q; mm_b1_o = z1_q;   mm_b2_o = z2_q; end
      default:   begin mm_a1_o = p1_q;     mm_a2_o = p2_q; mm_b1_o = ONE;    mm_b2_o = '0;   end
    endcase
  end

  assign mm_start_o = (state_q != ST_IDLE) && !issued_q;
  assign mm_mod_o   = m_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; issued_q <= 1'b0; done_q <= 1'b0; idx_q <= '0;
      x_q <= '0; m_q <= '0; k_q <= '0; e_q <= '0; res_q <= '0;
      p1_q <= '0; p2_q <= '0; z1_q <= '0; z2_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          x_q <= base_i; e_q <= exp_i; m_q <= mod_i; k_q <= rsq_i;
          idx_q <= '0; issued_q <= 1'b0;
          state_q <= ST_INIT_P;
        end
      end else if (!issued_q) begin
        issued_q <= 1'b1;
      end else if (op_done_w) begin
        issued_q <= 1'b0;
        case (state_q)
          ST_INIT_P: begin
            p1_q <= mm_s1_i; p2_q <= mm_s2_i;
            state_q <= ST_INIT_Z;
          end
          ST_INIT_Z: begin
            z1_q <= mm_s1_i; z2_q <= mm_s2_i;
            state_q <= route(e_q[0], last_bit_w);
          end
          ST_MUL: begin
            p1_q <= mm_s1_i; p2_q <= mm_s2_i;
            state_q <= last_bit_w ? ST_FINAL : ST_SQR;
          end
          ST_SQR: begin
            z1_q <= mm_s1_i; z2_q <= mm_s2_i;
            idx_q <= nidx_w;
            state_q <= route(next_bit_w, next_last_w);
          end
          ST_FINAL: begin
            res_q   <= fin_i;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = res_q;

  AST_START_BUSY:  assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);  // R1
  AST_MM_IDLE:     assert property (@(posedge clk) disable iff (!rst_n)
    mm_start_o |-> !mm_busy_i);  // R2
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R6
  AST_DONE_IDLE:   assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);  // R6
  AST_RES_RANGE:   assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o < m_q));  // R5
  AST_RES_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> $stable(result_o));  // R6
  AST_OPS_FROZEN:  assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(m_q) && $stable(e_q) && $stable(x_q)));  // R7
endmodule

// File: rtl/mexp_core.sv
`timescale 1ns/1ps
module mexp_core #(
  parameter int W  = 16,
  parameter int EW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [W-1:0]  base_i,
  input  logic [EW-1:0] exp_i,
  input  logic [W-1:0]  mod_i,
  input  logic [W-1:0]  rsq_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  result_o
);
  localparam int DW = W + 3;

  logic          mm_start, mm_busy, mm_done;
  logic [DW-1:0] mm_a1, mm_a2, mm_b1, mm_b2, mm_s1, mm_s2;
  logic [W-1:0]  mm_mod, fin_res;

  mexp_seq #(.W(W), .EW(EW)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .base_i(base_i), .exp_i(exp_i), .mod_i(mod_i), .rsq_i(rsq_i),
    .mm_busy_i(mm_busy), .mm_done_i(mm_done), .mm_s1_i(mm_s1), .mm_s2_i(mm_s2),
    .fin_i(fin_res), .mm_start_o(mm_start),
    .mm_a1_o(mm_a1), .mm_a2_o(mm_a2), .mm_b1_o(mm_b1), .mm_b2_o(mm_b2),
    .mm_mod_o(mm_mod), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  mexp_mont_mul #(.W(W)) mul_i (
    .clk(clk), .rst_n(rst_n), .start_i(mm_start),
    .a1_i(mm_a1), .a2_i(mm_a2), .b1_i(mm_b1), .b2_i(mm_b2), .mod_i(mm_mod),
    .busy_o(mm_busy), .done_o(mm_done), .s1_o(mm_s1), .s2_o(mm_s2)
  );

  mexp_finalize #(.W(W)) fin_i (
    .s1_i(mm_s1), .s2_i(mm_s2), .mod_i(mm_mod), .res_o(fin_res)
  );
endmodule

// File: tb/mexp_core_tb_top.sv
`timescale 1ns/1ps
module mexp_core_tb_top;
  localparam int W  = 16;
  localparam int EW = 16;
  localparam int NV = 6;
  // columns: base, exponent, modulus, expected
  localparam longint VEC [NV][4] = '{
    '{3,     4,     7,     4},
    '{5,     3,     13,    8},
    '{4,     13,    497,   445},
    '{2,     65520, 65521, 1},
    '{65534, 65535, 65535, 65534},
    '{3,     65520, 65521, 1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  base = '0, modv = '0, rsq = '0;
  logic [EW-1:0] expo = '0;
  logic          busy, done;
  logic [W-1:0]  res;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  logic   busy_seen;
  logic   done_seen;
  longint got;
  logic [31:0] rs = 32'h1357_9bdf;

  always #10 clk = ~clk;

  mexp_core #(.W(W), .EW(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base), .exp_i(expo),
    .mod_i(modv), .rsq_i(rsq), .busy_o(busy), .done_o(done), .result_o(res)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 180000) begin
      nerr = nerr + 1;
      $display("FAIL watchdog expired actual %0d expected below 180000", cyc);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  function automatic longint ref_pow(input longint x, input longint e, input longint m);
    longint r, b;
    r = 1 % m;
    b = x % m;
    for (int i = 0; i < EW; i++) begin
      if (e[i]) r = (r * b) % m;
      b = (b * b) % m;
    end
    return r;
  endfunction

  function automatic longint ref_k(input longint m);
    longint v = 1;
    for (int i = 0; i < 2 * (W + 2); i++) v = (v * 2) % m;
    return v;
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] v);
    logic [31:0] t = v;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    nchk = nchk + 1;
    if (act != exp) begin
      nerr = nerr + 1;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic launch(input longint x, input longint e, input longint m);
    @(negedge clk);
    base = W'(x); expo = EW'(e); modv = W'(m); rsq = W'(ref_k(m));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_seen = busy;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    done_seen = done;
    got = longint'(res);
  endtask

  task automatic run_op(input longint x, input longint e, input longint m);
    launch(x, e, m);
    wait_done();
  endtask

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 busy in reset", longint'(busy), 0);
    check("R8 done in reset", longint'(done), 0);
    check("R8 result in reset", longint'(res), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 busy after reset", longint'(busy), 0);
    check("R8 result after reset", longint'(res), 0);

    // R1 and R6 on a first operation
    run_op(3, 4, 7);
    check("R1 busy after start", longint'(busy_seen), 1);
    check("R6 done seen", longint'(done_seen), 1);
    check("R6 busy low with done", longint'(busy), 0);
    check("R2 3^4 mod 7", got, 4);
    @(negedge clk);
    check("R6 done single cycle", longint'(done), 0);
    check("R6 result held", longint'(res), 4);

    // R2: vector table
    for (int v = 0; v < NV; v++) begin
      run_op(VEC[v][0], VEC[v][1], VEC[v][2]);
      check("R2 table done", longint'(done_seen), 1);
      check("R2 table value", got, VEC[v][3]);
    end

    // R2, R5: pseudo-random odd moduli
    for (int k = 0; k < 20; k++) begin
      longint m, x, e;
      rs = xs(rs); m = longint'(rs[15:0]) | 1;
      if (m < 3) m = 3;
      rs = xs(rs); x = longint'(rs[15:0]) % m;
      rs = xs(rs); e = longint'(rs[15:0]);
      run_op(x, e, m);
      check("R2 random value", got, ref_pow(x, e, m));
      check("R5 random below modulus", longint'(got < m), 1);
    end

    // R3: zero exponent
    run_op(7, 0, 11);
    check("R3 7^0 mod 11", got, 1);
    run_op(0, 0, 9);
    check("R3 0^0 mod 9", got, 1);

    // R4 and R5: zero base, the pre-subtraction sum equals M
    run_op(0, 5, 9);
    check("R4 0^5 mod 9", got, 0);
    run_op(0, 65535, 65521);
    check("R5 zero base stays below modulus", got, 0);
    run_op(65534, 2, 65535);
    check("R5 wide modulus", got, 1);

    // R9: unit exponent
    run_op(10, 1, 17);
    check("R9 10^1 mod 17", got, 10);
    run_op(12345, 1, 65521);
    check("R9 12345^1 mod 65521", got, 12345);

    // R7: start while busy is ignored
    launch(2, 65520, 65521);
    repeat (30) @(negedge clk);
    base = 16'd3; expo = 16'd5; modv = 16'd7; rsq = W'(ref_k(7));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check("R7 first operands kept", got, 1);
    repeat (10) @(negedge clk);
    check("R7 no second run", longint'(busy), 0);
    check("R6 result held while idle", longint'(res), 1);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule